// File: doc/BRIEF.md
# Oscilloscope capture sequencer

This block runs one acquisition into a circular sample buffer of `DEPTH` positions (1024 by default). Software control pulses can reset the sequencer, arm a capture or force a trigger. After arming, the block writes a programmable number of pretrigger samples. It then waits for a trigger and writes the remaining post-trigger samples. The filled buffer is then handed to the host for read-back.

The sample strobe gates every buffer write. The block drives the write address and write enable of the sample memory. It also drives the read address used during read-back. A 4-bit status code shows the current phase to software. Read-back starts at the oldest stored sample, so the host receives the samples in time order. Trigger detection, the converter interface and the host transport are handled elsewhere.

Top module: `cap_seq`

## Requirements
- R1: While `rst_ni` is low, status is 0. It returns to 0 after any reset pulse. From status 0 the block moves by itself to status 1 (waiting for arm) on the next clock.
- R2: `fsm_rst_i` high at a clock edge puts the status at 0 and the write address at 0 after that edge, whatever the current state.
- R3: `arm_i` high in status 1 gives status 2 (armed) after the edge, with the write address at 0. The following cycle gives status 3 (filling pretrigger), or status 4 if the pretrigger length is 0.
- R4: The pretrigger length is `trig_pos_i`, clamped to `DEPTH`-1, captured when the arm is accepted. The block stays in status 3 for exactly that many strobed writes, then enters status 4. Both `trig_i` and `force_trig_i` have no effect in status 3.
- R5: In status 4, samples keep being written. `trig_i` or `force_trig_i` high at an edge gives status 5 (filling post-trigger) after it. The sample strobed in that same cycle counts as a pretrigger write.
- R6: In status 5, exactly `DEPTH` minus the pretrigger length strobed writes occur. The block then enters status 6 (capture complete).
- R7: `wr_en_o` equals `smp_en_i` in statuses 3, 4 and 5 and is 0 in every other status. Each write advances `wr_addr_o` by one, modulo `DEPTH`.
- R8: In status 6, `read_mode_i` high gives status 7 (reading). On entry to status 7, `rd_addr_o` equals the address following the last written sample. Each cycle with `rd_req_i` high in status 7 advances `rd_addr_o` by one, modulo `DEPTH`.
- R9: After `DEPTH` read requests, the block enters status 8. It stays there while `read_mode_i` is high. It returns to status 1 one cycle after `read_mode_i` goes low.
- R10: `arm_i` has no effect outside status 1, and trigger inputs have no effect outside status 4. Status codes above 8 never occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsm_rst_i | input | 1 | Single-cycle sequencer reset pulse |
| arm_i | input | 1 | Single-cycle arm pulse |
| force_trig_i | input | 1 | Single-cycle forced trigger pulse |
| trig_i | input | 1 | Trigger event from the detector |
| smp_en_i | input | 1 | Sample strobe |
| trig_pos_i | input | 16 | Pretrigger length in samples |
| read_mode_i | input | 1 | 1 selects host read-back, 0 acquisition |
| rd_req_i | input | 1 | Host read strobe, advances the read address |
| status_o | output | 4 | Phase code 0..8 |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | 10 | Buffer write address |
| rd_addr_o | output | 10 | Buffer read address |

## Verification
The assertions assume that the control pulses last a single cycle. They also assume that `trig_pos_i` stays constant around the arm pulse and that `read_mode_i` is driven only around the complete and read phases. The bench drives every pulse for exactly one cycle from the falling edge. It keeps the sample strobe high through all capture phases, so the write count can be predicted from the cycle count. It raises and lowers read mode only in status 6 and status 8.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;
  typedef enum logic [3:0] {
    ST_RESET     = 4'd0,
    ST_WAIT_ARM  = 4'd1,
    ST_ARMED     = 4'd2,
    ST_FILL_PRE  = 4'd3,
    ST_WAIT_TRIG = 4'd4,
    ST_FILL_POST = 4'd5,
    ST_DONE      = 4'd6,
    ST_READ      = 4'd7,
    ST_READ_END  = 4'd8
  } cap_state_e;
endpackage

// File: rtl/cap_seq_fsm.sv
module cap_seq_fsm
  import cap_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fsm_rst_i,
  input  logic       arm_i,
  input  logic       trig_hit_i,
  input  logic       smp_en_i,
  input  logic       read_mode_i,
  input  logic       rd_req_i,
  input  logic       pre_zero_i,
  input  logic       pre_last_i,
  input  logic       post_last_i,
  input  logic       rd_last_i,
  output cap_state_e state_o
);
  cap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET:     state_d = ST_WAIT_ARM;
      ST_WAIT_ARM:  if (arm_i) state_d = ST_ARMED;
      ST_ARMED:     state_d = pre_zero_i ? ST_WAIT_TRIG : ST_FILL_PRE;
      ST_FILL_PRE:  if (smp_en_i && pre_last_i) state_d = ST_WAIT_TRIG;
      ST_WAIT_TRIG: if (trig_hit_i) state_d = ST_FILL_POST;
      ST_FILL_POST: if (smp_en_i && post_last_i) state_d = ST_DONE;
      ST_DONE:      if (read_mode_i) state_d = ST_READ;
      ST_READ:      if (rd_req_i && rd_last_i) state_d = ST_READ_END;
      ST_READ_END:  if (!read_mode_i) state_d = ST_WAIT_ARM;
      default:      state_d = ST_RESET;
    endcase
    if (fsm_rst_i) state_d = ST_RESET;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cap_seq_wr.sv
module cap_seq_wr
  import cap_seq_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int POS_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cap_state_e       state_i,
  input  logic             fsm_rst_i,
  input  logic             arm_i,
  input  logic             trig_hit_i,
  input  logic             smp_en_i,
  input  logic [POS_W-1:0] trig_pos_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic             pre_zero_o,
  output logic             pre_last_o,
  output logic             post_last_o
);
  logic [AW-1:0] pre_len_q, cnt_q, addr_q, pre_clamp;
  logic          arm_go, trig_go, capturing;

  assign capturing = (state_i == ST_FILL_PRE) || (state_i == ST_WAIT_TRIG) ||
                     (state_i == ST_FILL_POST);
  assign wr_en_o   = smp_en_i && capturing;
  assign arm_go    = (state_i == ST_WAIT_ARM) && arm_i;
  assign trig_go   = (state_i == ST_WAIT_TRIG) && trig_hit_i;

  always_comb begin
    if (32'(trig_pos_i) >= DEPTH) pre_clamp = AW'(DEPTH - 1);
    else                          pre_clamp = trig_pos_i[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_len_q <= '0;
      cnt_q     <= '0;
      addr_q    <= '0;
    end else if (fsm_rst_i) begin
      cnt_q     <= '0;
      addr_q    <= '0;
    end else begin
      if (arm_go) begin
        pre_len_q <= pre_clamp;
        cnt_q     <= '0;
        addr_q    <= '0;
      end else begin
        if (wr_en_o) addr_q <= addr_q + AW'(1);
        // counter restarts for the post-trigger region
        if (trig_go)      cnt_q <= '0;
        else if (wr_en_o) cnt_q <= cnt_q + AW'(1);
      end
    end
  end

  assign wr_addr_o   = addr_q;
  assign pre_zero_o  = (pre_len_q == '0);
  assign pre_last_o  = (cnt_q == pre_len_q - AW'(1));
  assign post_last_o = (cnt_q == AW'(DEPTH - 1) - pre_len_q);
endmodule

// File: rtl/cap_seq_rd.sv
module cap_seq_rd
  import cap_seq_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cap_state_e    state_i,
  input  logic          fsm_rst_i,
  input  logic          read_mode_i,
  input  logic          rd_req_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_last_o
);
  logic [AW-1:0] addr_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (fsm_rst_i) begin
      cnt_q  <= '0;
    end else if ((state_i == ST_DONE) && read_mode_i) begin
      // write pointer now sits on the oldest sample
      addr_q <= wr_addr_i;
      cnt_q  <= '0;
    end else if ((state_i == ST_READ) && rd_req_i) begin
      addr_q <= addr_q + AW'(1);
      cnt_q  <= cnt_q + AW'(1);
    end
  end

  assign rd_addr_o = addr_q;
  assign rd_last_o = (cnt_q == AW'(DEPTH - 1));
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_seq_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int POS_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsm_rst_i,
  input  logic             arm_i,
  input  logic             force_trig_i,
  input  logic             trig_i,
  input  logic             smp_en_i,
  input  logic [POS_W-1:0] trig_pos_i,
  input  logic             read_mode_i,
  input  logic             rd_req_i,
  output logic [3:0]       status_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [AW-1:0]    rd_addr_o
);
  cap_state_e state;
  logic       trig_hit, pre_zero, pre_last, post_last, rd_last;

  assign trig_hit = trig_i || force_trig_i;

  cap_seq_fsm u_fsm (
    .clk_i, .rst_ni, .fsm_rst_i, .arm_i,
    .trig_hit_i  (trig_hit),
    .smp_en_i, .read_mode_i, .rd_req_i,
    .pre_zero_i  (pre_zero),
    .pre_last_i  (pre_last),
    .post_last_i (post_last),
    .rd_last_i   (rd_last),
    .state_o     (state)
  );

  cap_seq_wr #(.DEPTH(DEPTH), .POS_W(POS_W)) u_wr (
    .clk_i, .rst_ni,
    .state_i     (state),
    .fsm_rst_i, .arm_i,
    .trig_hit_i  (trig_hit),
    .smp_en_i, .trig_pos_i, .wr_en_o, .wr_addr_o,
    .pre_zero_o  (pre_zero),
    .pre_last_o  (pre_last),
    .post_last_o (post_last)
  );

  cap_seq_rd #(.DEPTH(DEPTH)) u_rd (
    .clk_i, .rst_ni,
    .state_i     (state),
    .fsm_rst_i, .read_mode_i, .rd_req_i,
    .wr_addr_i   (wr_addr_o),
    .rd_addr_o,
    .rd_last_o   (rd_last)
  );

  assign status_o = state;
endmodule

// File: rtl/cap_seq_chk.sv
module cap_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fsm_rst_i,
  input logic          arm_i,
  input logic          force_trig_i,
  input logic          trig_i,
  input logic          smp_en_i,
  input logic          read_mode_i,
  input logic          rd_req_i,
  input logic [3:0]    status_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [AW-1:0] rd_addr_o
);
  AST_LEAVE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'd0 && !fsm_rst_i) |=> status_o == 4'd1); // R1
  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_rst_i |=> (status_o == 4'd0 && wr_addr_o == '0)); // R2
  AST_ARM_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'd1 && arm_i && !fsm_rst_i) |=> status_o == 4'd2); // R3
  AST_ARM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 4'd2 |-> wr_addr_o == '0); // R3
  AST_NO_EARLY_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'd3 && !fsm_rst_i) |=> (status_o == 4'd3 || status_o == 4'd4)); // R4
  AST_TRIG_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'd4 && (trig_i || force_trig_i) && !fsm_rst_i) |=> status_o == 4'd5); // R5
  AST_WR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (smp_en_i && status_o >= 4'd3 && status_o <= 4'd5)); // R7
  AST_WR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !fsm_rst_i) |=> wr_addr_o == $past(wr_addr_o) + AW'(1)); // R7
  AST_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'd7 && rd_req_i && !fsm_rst_i) |=> rd_addr_o == $past(rd_addr_o) + AW'(1)); // R8
  AST_END_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'd8 && read_mode_i && !fsm_rst_i) |=> status_o == 4'd8); // R9
  AST_STATUS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o <= 4'd8); // R10
  AST_ARM_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'd6 && arm_i && !read_mode_i && !fsm_rst_i) |=> status_o == 4'd6); // R10
endmodule

bind cap_seq cap_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fsm_rst_i(fsm_rst_i), .arm_i(arm_i),
  .force_trig_i(force_trig_i), .trig_i(trig_i), .smp_en_i(smp_en_i),
  .read_mode_i(read_mode_i), .rd_req_i(rd_req_i), .status_o(status_o),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .rd_addr_o(rd_addr_o)
);

// File: tb/cap_seq_tb.sv
module cap_seq_tb;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int NVEC  = 6;
  // columns: trig_pos, extra wait samples, use force, hold triggers in fill, expected pre length
  localparam int VEC [NVEC][5] = '{
    '{512,  0,    0, 1, 512},
    '{0,    3,    1, 0, 0},
    '{1,    0,    0, 1, 1},
    '{2000, 2,    1, 1, 1023},
    '{1023, 5,    0, 0, 1023},
    '{100,  1030, 0, 0, 100}
  };

  logic clk_i = 0, rst_ni = 0;
  logic fsm_rst_i = 0, arm_i = 0, force_trig_i = 0, trig_i = 0, smp_en_i = 0;
  logic read_mode_i = 0, rd_req_i = 0;
  logic [15:0] trig_pos_i = '0;
  logic [3:0] status_o;
  logic wr_en_o;
  logic [AW-1:0] wr_addr_o, rd_addr_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  cap_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_capture(input int pos, input int extra, input bit frc, input bit hold,
                             input int exp_pre);
    int n;
    int oldest;
    trig_pos_i = 16'(pos);
    arm_i = 1;
    @(negedge clk_i);
    arm_i = 0;
    chk(status_o == 2, "R3 armed", status_o, 2);
    chk(wr_addr_o == 0, "R3 addr", wr_addr_o, 0);
    smp_en_i = 1;
    @(negedge clk_i);
    n = 0;
    while (status_o == 3 && n < DEPTH + 5) begin
      if (hold) begin trig_i = 1; force_trig_i = 1; end
      n++;
      @(negedge clk_i);
    end
    trig_i = 0; force_trig_i = 0;
    chk(n == exp_pre, "R4 pre count", n, exp_pre);
    chk(status_o == 4, "R4 wait trig", status_o, 4);
    repeat (extra) @(negedge clk_i);
    chk(status_o == 4, "R5 no trig", status_o, 4);
    if (frc) force_trig_i = 1; else trig_i = 1;
    @(negedge clk_i);
    force_trig_i = 0; trig_i = 0;
    chk(status_o == 5, "R5 triggered", status_o, 5);
    n = 0;
    while (status_o == 5 && n < DEPTH + 5) begin n++; @(negedge clk_i); end
    chk(n == DEPTH - exp_pre, "R6 post count", n, DEPTH - exp_pre);
    chk(status_o == 6, "R6 done", status_o, 6);
    oldest = (extra + 1) % DEPTH;
    chk(wr_addr_o == AW'(oldest), "R7 wr addr", wr_addr_o, oldest);
    smp_en_i = 0;
    #1 chk(wr_en_o == 0, "R7 wr_en off", wr_en_o, 0);
    arm_i = 1;
    @(negedge clk_i);
    arm_i = 0;
    chk(status_o == 6, "R10 arm ignored", status_o, 6);
    read_mode_i = 1;
    @(negedge clk_i);
    chk(status_o == 7, "R8 reading", status_o, 7);
    chk(rd_addr_o == AW'(oldest), "R8 oldest", rd_addr_o, oldest);
    rd_req_i = 1;
    repeat (DEPTH - 1) @(negedge clk_i);
    chk(status_o == 7, "R9 still reading", status_o, 7);
    chk(rd_addr_o == AW'((oldest + DEPTH - 1) % DEPTH), "R8 rd addr",
        rd_addr_o, (oldest + DEPTH - 1) % DEPTH);
    @(negedge clk_i);
    rd_req_i = 0;
    chk(status_o == 8, "R9 read end", status_o, 8);
    @(negedge clk_i);
    chk(status_o == 8, "R9 hold", status_o, 8);
    read_mode_i = 0;
    @(negedge clk_i);
    chk(status_o == 1, "R9 back to arm", status_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(status_o == 0, "R1 reset status", status_o, 0);
    #1 chk(wr_en_o == 0, "R7 reset wr_en", wr_en_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(status_o == 1, "R1 auto wait arm", status_o, 1);

    trig_i = 1;
    @(negedge clk_i);
    trig_i = 0;
    chk(status_o == 1, "R10 trig ignored", status_o, 1);

    for (int i = 0; i < NVEC; i++)
      run_capture(VEC[i][0], VEC[i][1], VEC[i][2] != 0, VEC[i][3] != 0, VEC[i][4]);

    // soft reset in the middle of post-trigger filling
    trig_pos_i = 16'd8;
    arm_i = 1;
    @(negedge clk_i);
    arm_i = 0;
    smp_en_i = 1;
    repeat (12) @(negedge clk_i);
    chk(status_o == 4, "R4 short pre", status_o, 4);
    trig_i = 1;
    @(negedge clk_i);
    trig_i = 0;
    repeat (3) @(negedge clk_i);
    chk(status_o == 5, "R5 post", status_o, 5);
    fsm_rst_i = 1;
    @(negedge clk_i);
    fsm_rst_i = 0;
    smp_en_i = 0;
    chk(status_o == 0, "R2 soft reset", status_o, 0);
    chk(wr_addr_o == 0, "R2 addr cleared", wr_addr_o, 0);
    @(negedge clk_i);
    chk(status_o == 1, "R1 leave reset", status_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule